// File: doc/BRIEF.md
# Segmented Transmit Bus Protocol Checker

This block is a passive monitor for a wide transmit stream that is cut into segments. In four-segment mode all segments are in use. In two-segment mode only the lower two are used. Each segment carries its own header-start flag, data-valid flag, end-of-packet flag and a byte keep field. The whole bus shares one valid/ready pair and one last flag. The checker drives nothing back onto the bus. It only watches the bus and reports rule breaks, one output per rule.

A beat is transferred in any cycle in which valid and ready are both high. Back-pressure works as follows. The sink may drop ready at any time. The source then has four cycles to drop valid. If a packet was cut off by the stall, valid must come back no later than one cycle after ready rises again. Once ready is high again, valid may not fall in the middle of a packet. The packing rules (where a packet may start, fill order, keep use) are judged only on transferred beats.

Each error output pulses for one cycle, in the cycle after the offending bus cycle. A sticky summary bit collects every pulse and is cleared only by reset.

Top module: `seg_stream_checker`

## Requirements
- R1: In four-segment mode (`quad_mode`=1), a transferred beat with a header flag on segment 1 or segment 3 (`seg_hdr` bit i is segment i) raises `err_start`. This rule is not applied in two-segment mode.
- R2: In four-segment mode, a transferred beat with a header on segment 2 while segment 0 is idle (neither header nor data flag set) raises `err_pack`. If segment 0 holds a header or data, and segment 1 is either idle or data, the beat is legal.
- R3: In two-segment mode, a transferred beat with a header on segment 1 while segment 0 is idle raises `err_pack`. Segments 2 and 3 are ignored in this mode.
- R4: On a transferred beat with `tx_last`=0, an active segment whose keep field (`seg_keep[i*KEEP_W +: KEEP_W]`) is not all ones raises `err_keep`. Partial keep on a last beat, and keep on idle segments, are allowed.
- R5: With valid high, `err_drain` is raised in the fifth and every later consecutive cycle of ready low. The first four cycles of ready low are tolerated.
- R6: If ready falls while a packet is open and later rises again, valid must be high in the first or second cycle of ready high. Otherwise `err_resume` is raised for that second cycle.
- R7: After a transferred non-last beat, a cycle with ready high and valid low raises `err_gap`.
- R8: On a transferred beat, `err_order` is raised in either of two cases. The first: a packet is open and segment 0 is idle. The second: a live segment carries data without a header while the segment below it is idle or ended a packet (`seg_end`).
- R9: Every error output is a registered pulse, high only in the cycle after the offending cycle. `err_sticky` rises with the first pulse, stays high until reset, and is low out of reset.
- R10: Packing and keep rules ignore beats presented while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| quad_mode | input | 1 | 1 = four segments, 0 = two segments |
| tx_valid | input | 1 | Source has a beat |
| tx_ready | input | 1 | Sink accepts the beat |
| tx_last | input | 1 | No packet stays open after this beat |
| seg_hdr | input | NSEG | Packet header starts in segment i |
| seg_dv | input | NSEG | Segment i carries data |
| seg_end | input | NSEG | A packet ends in segment i |
| seg_keep | input | NSEG*KEEP_W | Byte keep, KEEP_W bits per segment |
| err_start | output | 1 | Illegal start segment pulse |
| err_pack | output | 1 | Illegal upper-half start pattern pulse |
| err_order | output | 1 | Out-of-order segment fill pulse |
| err_keep | output | 1 | Partial keep on non-last beat pulse |
| err_drain | output | 1 | Valid held too long after ready fell |
| err_resume | output | 1 | Suspended packet resumed too late |
| err_gap | output | 1 | Valid dropped mid-packet with ready high |
| err_sticky | output | 1 | Latched OR of all pulses |

## Verification
One beat can break a start rule and a keep rule at the same time. The bench sends a non-last beat in four-segment mode with a header on segment 3 and a partial keep on that same segment. It expects `err_start` and `err_keep` to pulse together in the next cycle, with no other flag. A stall sequence is also checked: the resume deadline follows a drain fault, so the bench checks that each flag lands in its own cycle and that the gap rule stays quiet while the resume rule is being judged.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  typedef struct packed {
    logic start;
    logic pack;
    logic order;
    logic keep;
    logic drain;
    logic resume;
    logic gap;
  } rule_flags_t;
endpackage

// File: rtl/segchk_beat_rules.sv
module segchk_beat_rules #(
  parameter int NSEG   = 4,
  parameter int KEEP_W = 32
) (
  input  logic                   quad_mode,
  input  logic                   xfer,
  input  logic                   last,
  input  logic                   in_pkt,
  input  logic [NSEG-1:0]        hdr,
  input  logic [NSEG-1:0]        dv,
  input  logic [NSEG-1:0]        seg_end,
  input  logic [NSEG*KEEP_W-1:0] keep,
  output logic                   start_hit,
  output logic                   pack_hit,
  output logic                   order_hit,
  output logic                   keep_hit
);
  localparam int HALF = NSEG / 2;

  logic [NSEG-1:0] live, act, odd_hdr, part, hole;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam bit ODD = (g % 2) == 1;
    assign live[g]    = quad_mode || (g < HALF);
    assign act[g]     = live[g] && (hdr[g] || dv[g]);
    assign odd_hdr[g] = ODD && hdr[g];
    assign part[g]    = act[g] && !(&keep[g*KEEP_W +: KEEP_W]);
    if (g == 0) begin : g_first
      assign hole[g] = in_pkt && !act[0];
    end else begin : g_upper
      assign hole[g] = live[g] && dv[g] && !hdr[g] &&
                       (!act[g-1] || seg_end[g-1]);
    end
  end

  always_comb begin
    start_hit = xfer && quad_mode && (|odd_hdr);
    if (quad_mode) pack_hit = xfer && hdr[HALF] && !act[0];
    else           pack_hit = xfer && hdr[1] && !act[0];
    order_hit = xfer && (|hole);
    keep_hit  = xfer && !last && (|part);
  end
endmodule

// File: rtl/segchk_handshake.sv
module segchk_handshake #(
  parameter int DRAIN_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic ready,
  input  logic last,
  output logic in_pkt,
  output logic drain_hit,
  output logic resume_hit,
  output logic gap_hit
);
  localparam int CW = $clog2(DRAIN_MAX + 1) + 1;

  logic [CW-1:0] low_run;
  logic          susp, up1, open_prev, xfer;

  assign xfer = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      open_prev <= 1'b0;
      low_run   <= '0;
      susp      <= 1'b0;
      up1       <= 1'b0;
    end else begin
      if (xfer) in_pkt <= !last;
      open_prev <= xfer && !last;
      if (ready) low_run <= '0;
      else if (low_run < CW'(DRAIN_MAX)) low_run <= low_run + 1'b1;
      if (!ready && in_pkt) begin
        susp <= 1'b1;
        up1  <= 1'b0;
      end else if (susp && ready) begin
        if (valid || up1) begin
          susp <= 1'b0;
          up1  <= 1'b0;
        end else begin
          up1 <= 1'b1;
        end
      end
    end
  end

  assign drain_hit  = valid && !ready && (low_run >= CW'(DRAIN_MAX));
  assign resume_hit = susp && ready && !valid && up1;
  assign gap_hit    = open_prev && ready && !valid;
endmodule

// File: rtl/segchk_flag_reg.sv
module segchk_flag_reg
  import segchk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  rule_flags_t hit,
  output rule_flags_t pulse,
  output logic        sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse  <= '0;
      sticky <= 1'b0;
    end else begin
      pulse  <= hit;
      sticky <= sticky || (|hit);
    end
  end
endmodule

// File: rtl/seg_stream_checker.sv
module seg_stream_checker
  import segchk_pkg::*;
#(
  parameter int NSEG      = 4,
  parameter int KEEP_W    = 32,
  parameter int DRAIN_MAX = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   quad_mode,
  input  logic                   tx_valid,
  input  logic                   tx_ready,
  input  logic                   tx_last,
  input  logic [NSEG-1:0]        seg_hdr,
  input  logic [NSEG-1:0]        seg_dv,
  input  logic [NSEG-1:0]        seg_end,
  input  logic [NSEG*KEEP_W-1:0] seg_keep,
  output logic                   err_start,
  output logic                   err_pack,
  output logic                   err_order,
  output logic                   err_keep,
  output logic                   err_drain,
  output logic                   err_resume,
  output logic                   err_gap,
  output logic                   err_sticky
);
  rule_flags_t hit, pulse;
  logic        in_pkt;

  segchk_handshake #(.DRAIN_MAX(DRAIN_MAX)) u_hs (
    .clk(clk), .rst_n(rst_n), .valid(tx_valid), .ready(tx_ready),
    .last(tx_last), .in_pkt(in_pkt), .drain_hit(hit.drain),
    .resume_hit(hit.resume), .gap_hit(hit.gap)
  );

  segchk_beat_rules #(.NSEG(NSEG), .KEEP_W(KEEP_W)) u_beat (
    .quad_mode(quad_mode), .xfer(tx_valid && tx_ready), .last(tx_last),
    .in_pkt(in_pkt), .hdr(seg_hdr), .dv(seg_dv), .seg_end(seg_end),
    .keep(seg_keep), .start_hit(hit.start), .pack_hit(hit.pack),
    .order_hit(hit.order), .keep_hit(hit.keep)
  );

  segchk_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .hit(hit), .pulse(pulse), .sticky(err_sticky)
  );

  assign err_start  = pulse.start;
  assign err_pack   = pulse.pack;
  assign err_order  = pulse.order;
  assign err_keep   = pulse.keep;
  assign err_drain  = pulse.drain;
  assign err_resume = pulse.resume;
  assign err_gap    = pulse.gap;
endmodule

// File: rtl/seg_stream_checker_sva.sv
module seg_stream_checker_sva #(
  parameter int NSEG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            quad_mode,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic [NSEG-1:0] seg_hdr,
  input logic            err_start,
  input logic            err_pack,
  input logic            err_order,
  input logic            err_keep,
  input logic            err_drain,
  input logic            err_resume,
  input logic            err_gap,
  input logic            err_sticky
);
  assert_odd_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && quad_mode && (seg_hdr[1] || seg_hdr[3])) |=> err_start);

  assert_pack_on_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_pack |-> $past(tx_valid && tx_ready));

  assert_keep_on_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_keep || err_order || err_start) |-> $past(tx_valid && tx_ready));

  assert_drain_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_drain |-> $past(tx_valid && !tx_ready));

  assert_resume_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_resume |-> $past(tx_ready && !tx_valid));

  assert_gap_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_gap |-> $past(tx_ready && !tx_valid));

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_sticky_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_start || err_pack || err_order || err_keep || err_drain ||
     err_resume || err_gap) |-> err_sticky);
endmodule

bind seg_stream_checker seg_stream_checker_sva #(.NSEG(NSEG)) u_sva (
  .clk(clk), .rst_n(rst_n), .quad_mode(quad_mode), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .seg_hdr(seg_hdr), .err_start(err_start),
  .err_pack(err_pack), .err_order(err_order), .err_keep(err_keep),
  .err_drain(err_drain), .err_resume(err_resume), .err_gap(err_gap),
  .err_sticky(err_sticky)
);

// File: tb/seg_stream_checker_tb.sv
module seg_stream_checker_tb;
  localparam int NSEG = 4;
  localparam int KW   = 32;
  localparam int NV   = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic quad_mode = 1'b1, tx_valid = 1'b0, tx_ready = 1'b1, tx_last = 1'b0;
  logic [NSEG-1:0] seg_hdr = '0, seg_dv = '0, seg_end = '0;
  logic [NSEG*KW-1:0] seg_keep = '1;
  logic err_start, err_pack, err_order, err_keep, err_drain, err_resume, err_gap, err_sticky;
  int checks = 0, fails = 0;
  logic exp_sticky = 1'b0;

  always #5 clk = ~clk;

  seg_stream_checker u_dut (
    .clk(clk), .rst_n(rst_n), .quad_mode(quad_mode), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_last(tx_last), .seg_hdr(seg_hdr), .seg_dv(seg_dv),
    .seg_end(seg_end), .seg_keep(seg_keep), .err_start(err_start),
    .err_pack(err_pack), .err_order(err_order), .err_keep(err_keep),
    .err_drain(err_drain), .err_resume(err_resume), .err_gap(err_gap),
    .err_sticky(err_sticky)
  );

  // {quad, valid, ready, last, hdr, dv, end, keep_full, expected flags}
  // flags: {start R1, pack R2/R3, order R8, keep R4, drain R5, resume R6, gap R7}
  localparam logic [26:0] VEC [NV] = '{
    {4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 7'b0000000},
    {4'b1111, 4'b0001, 4'b0001, 4'b0001, 4'b1111, 7'b0000000},
    {4'b1111, 4'b0101, 4'b0101, 4'b0101, 4'b0000, 7'b0000000},
    {4'b1111, 4'b0010, 4'b0010, 4'b0010, 4'b1111, 7'b1000000},
    {4'b1111, 4'b0100, 4'b0100, 4'b0100, 4'b1111, 7'b0100000},
    {4'b1110, 4'b0001, 4'b1111, 4'b0000, 4'b1111, 7'b0000000},
    {4'b1111, 4'b0000, 4'b1101, 4'b1000, 4'b1111, 7'b0010000},
    {4'b1110, 4'b0001, 4'b1111, 4'b0000, 4'b1110, 7'b0001000},
    {4'b1100, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 7'b0000000},
    {4'b1100, 4'b0010, 4'b0010, 4'b0010, 4'b0000, 7'b0000000},
    {4'b1100, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 7'b0000000},
    {4'b1100, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 7'b0000000},
    {4'b1100, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 7'b0000100},
    {4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 7'b0000000},
    {4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 7'b0000000},
    {4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 7'b0000010},
    {4'b1110, 4'b0000, 4'b1111, 4'b0000, 4'b1111, 7'b0000000},
    {4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 7'b0000001},
    {4'b1111, 4'b0000, 4'b0001, 4'b0001, 4'b1111, 7'b0000000},
    {4'b0111, 4'b0010, 4'b0011, 4'b0011, 4'b1111, 7'b0000000},
    {4'b0111, 4'b0010, 4'b0010, 4'b0010, 4'b1111, 7'b0100000},
    {4'b0111, 4'b0011, 4'b1011, 4'b0011, 4'b1111, 7'b0000000},
    {4'b1111, 4'b0010, 4'b0011, 4'b0011, 4'b1111, 7'b1000000},
    {4'b1110, 4'b1001, 4'b1111, 4'b0000, 4'b0111, 7'b1001000},
    {4'b1111, 4'b0000, 4'b0001, 4'b0001, 4'b1111, 7'b0000000},
    {4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 7'b0000000}
  };

  function automatic string tags(input logic [6:0] e);
    string s = "";
    if (e[6]) s = {s, "R1 "};
    if (e[5]) s = {s, "R2/R3 "};
    if (e[4]) s = {s, "R8 "};
    if (e[3]) s = {s, "R4 "};
    if (e[2]) s = {s, "R5 "};
    if (e[1]) s = {s, "R6 "};
    if (e[0]) s = {s, "R7 "};
    if (e == 7'd0) s = "R10 quiet";
    return s;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] flags();
    return {err_start, err_pack, err_order, err_keep, err_drain, err_resume, err_gap};
  endfunction

  task automatic drive(input logic [26:0] v);
    quad_mode = v[26]; tx_valid = v[25]; tx_ready = v[24]; tx_last = v[23];
    seg_hdr = v[22:19]; seg_dv = v[18:15]; seg_end = v[14:11];
    for (int i = 0; i < NSEG; i++)
      seg_keep[i*KW +: KW] = v[7+i] ? {KW{1'b1}} : {{(KW/2){1'b0}}, {(KW/2){1'b1}}};
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    chk("R9 reset state", {flags(), err_sticky}, 8'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      @(negedge clk);
      chk(tags(VEC[k][6:0]), {1'b0, flags()}, {1'b0, VEC[k][6:0]});
      exp_sticky = exp_sticky | (|VEC[k][6:0]);
      chk("R9 sticky", {7'd0, err_sticky}, {7'd0, exp_sticky});
    end
    // R9: reset clears the sticky bit
    rst_n = 1'b0;
    drive(VEC[0]);
    @(negedge clk);
    @(negedge clk);
    chk("R9 sticky cleared", {flags(), err_sticky}, 8'd0);
    rst_n = 1'b1;
    // clean traffic keeps sticky low
    drive(VEC[1]);
    @(negedge clk);
    chk("R9 clean stays low", {flags(), err_sticky}, 8'd0);
    // R1 pulse: one cycle only, sticky rises with it and holds
    drive(VEC[3]);
    @(negedge clk);
    chk("R1 R9 pulse", {flags(), err_sticky}, {7'b1000000, 1'b1});
    drive(VEC[0]);
    @(negedge clk);
    chk("R9 pulse ends", {flags(), err_sticky}, {7'b0000000, 1'b1});
    @(negedge clk);
    chk("R9 sticky holds", {flags(), err_sticky}, {7'b0000000, 1'b1});
    summary();
  end
endmodule